// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block sits between a small 8-bit controller core and its external parallel bus. For each core read or write it decodes the 16-bit address into active-low chip selects. It runs a strobe window of fixed length and holds the core stalled until that window has finished. It then reports completion through a one-cycle ready pulse.

An 8-bit configuration register sets the block's behaviour. It selects what logic function appears on the configurable CS3 pin, and it can stretch accesses to the CS2 device with wait states. It can also hold the external read and write strobes inactive while the core works on internal address ranges. Finally, it picks one of four power-save policies. These policies decide when the address/data pads are driven. While the pads are undriven, the outgoing address and data registers keep their previous contents.

Top module: `xbus_cs_ctrl`

## Requirements
- R1: The configuration register resets to 0x00. Bits 5:0 read back what was written. Bits 7:6 always read 0, and writes to them are ignored.
- R2: During the strobe window, `cs3N` is low only for addresses 0x2000..0x5FFF, and `cs2N` is low only for the CS2 range (default 0x8000..0xFFFF). Outside the window both are high.
- R3: Config bits 3:2 select the `cs3PinN` function of the active-low signals. 00 gives cs3N. 01 gives cs3N|rdN. 10 gives cs3N|wrN. 11 gives ~((cs3N|rdN)&(cs3N|wrN)).
- R4: An access lasts 4 strobe cycles, and the active-low strobe (`rdN` for a read, `wrN` for a write) is low for all 4.
- R5: With config bit 4 set, an access to the CS2 range lasts 8 strobe cycles. Accesses to any other range still last 4.
- R6: `coreReady` stays low while the strobe window runs. It goes high for exactly one cycle once the window ends, and in that cycle both strobes are high.
- R7: With config bit 5 set, `rdN` and `wrN` stay high for accesses to 0x0000..0x1FFF and 0x6000..0x7FFF, and the access still takes its normal length. With the bit clear, these accesses strobe normally.
- R8: Power-save mode (config bits 1:0) 00 keeps `busOe` high at all times. Mode 11 keeps it low at all times.
- R9: Mode 01 drives `busOe` high during the strobe window only when `romMode` is 1. Mode 10 does so only when `romMode` is 1 and the address is at or above 0x8000.
- R10: An access whose bus is gated off leaves `busAddr` and `busDout` unchanged. A driven write loads `coreWdata` into `busDout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coreAddr | input | 16 | Core address, held until ready |
| coreRd | input | 1 | Core read request, held until ready |
| coreWr | input | 1 | Core write request, held until ready |
| coreWdata | input | 8 | Core write data |
| romMode | input | 1 | Core runs from mask ROM |
| cfgWe | input | 1 | Configuration register write enable |
| cfgWdata | input | 8 | Configuration write value |
| cfgRdata | output | 8 | Configuration read value |
| cs2N | output | 1 | CS2 chip select, active low |
| cs3N | output | 1 | Raw CS3 chip select, active low |
| cs3PinN | output | 1 | Configurable CS3 pin |
| rdN | output | 1 | External read strobe, active low |
| wrN | output | 1 | External write strobe, active low |
| busOe | output | 1 | Address/data pad output enable |
| busAddr | output | 16 | Registered outgoing address |
| busDout | output | 8 | Registered outgoing data |
| coreReady | output | 1 | Access complete; core stall ends |

## Verification
Two functions can act in the same cycle: wait-state stretching and power-save gating. Both can apply to one CS2 access made in mask-ROM mode. The bench sets power-save mode 10 with the wait enable, raises `romMode`, and writes to 0x9000. It then counts every cycle of the window. `busOe` must be high in all 8 stretched cycles and the write strobe must be low in all 8. `coreReady` must stay low until the ninth cycle. The same write made with `romMode` low must show 8 strobe cycles and no driven cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef struct packed {
    logic capture;  // idle and a request present: latch the access
    logic active;   // strobe window running
    logic done;     // window finished: release the core
  } busCtl_t;

  localparam int CFG_BLK_BIT  = 5;
  localparam int CFG_WAIT_BIT = 4;
  localparam int CFG_PIN_LSB  = 2;
  localparam int CFG_PS_LSB   = 0;
  localparam int CFG_USED_W   = 6;

  typedef enum logic [1:0] {
    PS_ON    = 2'b00,
    PS_ROM   = 2'b01,
    PS_ROMEX = 2'b10,
    PS_OFF   = 2'b11
  } psMode_t;

  typedef enum logic [1:0] {
    PIN_CS   = 2'b00,
    PIN_CSRD = 2'b01,
    PIN_CSWR = 2'b10,
    PIN_XOR  = 2'b11
  } pinMode_t;
endpackage

// File: rtl/xbus_ctl.sv
module xbus_ctl
  import xbus_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    longAcc,
  output busCtl_t ctl
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_DONE} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             longQ;
  logic             lastCyc;

  assign lastCyc = (cnt == (longQ ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      longQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req) begin
          state <= ST_STROBE;
          cnt   <= '0;
          longQ <= longAcc;
        end
        ST_STROBE: begin
          if (lastCyc) state <= ST_DONE;
          else         cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture = (state == ST_IDLE) && req;
    ctl.active  = (state == ST_STROBE);
    ctl.done    = (state == ST_DONE);
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> (cnt < CNT_W'(LONG_LEN)));
  p_short_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !longQ) |-> (cnt < CNT_W'(SHORT_LEN)));
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> !ctl.done);
  p_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (ctl.active && cnt == '0));
endmodule

// File: rtl/xbus_dp.sv
module xbus_dp
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CS2_LO  = 16'h8000,
  parameter logic [ADDR_W-1:0] CS2_HI  = 16'hFFFF,
  parameter logic [ADDR_W-1:0] CS3_LO  = 16'h2000,
  parameter logic [ADDR_W-1:0] CS3_HI  = 16'h5FFF,
  parameter logic [ADDR_W-1:0] INTA_LO = 16'h0000,
  parameter logic [ADDR_W-1:0] INTA_HI = 16'h1FFF,
  parameter logic [ADDR_W-1:0] INTB_LO = 16'h6000,
  parameter logic [ADDR_W-1:0] INTB_HI = 16'h7FFF,
  parameter logic [ADDR_W-1:0] EXT_LO  = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreWr,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic              romMode,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output logic              longAcc,
  output logic              cs2N,
  output logic              cs3N,
  output logic              cs3PinN,
  output logic              rdN,
  output logic              wrN,
  output logic              busOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout
);
  function automatic logic inRange(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] lo,
                                   input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [CFG_USED_W-1:0] cfgQ;
  logic     blkEn, waitEn;
  pinMode_t pinMode;
  psMode_t  psMode;

  logic wrQ, cs2HitQ, cs3HitQ, intHitQ, driveQ;
  logic driveNow, intNow;

  assign blkEn   = cfgQ[CFG_BLK_BIT];
  assign waitEn  = cfgQ[CFG_WAIT_BIT];
  assign pinMode = pinMode_t'(cfgQ[CFG_PIN_LSB +: 2]);
  assign psMode  = psMode_t'(cfgQ[CFG_PS_LSB +: 2]);
  assign cfgRdata = {{(8-CFG_USED_W){1'b0}}, cfgQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata[CFG_USED_W-1:0];
  end

  assign longAcc = waitEn && inRange(coreAddr, CS2_LO, CS2_HI);
  assign intNow  = inRange(coreAddr, INTA_LO, INTA_HI) ||
                   inRange(coreAddr, INTB_LO, INTB_HI);

  always_comb begin
    unique case (psMode)
      PS_ON:    driveNow = 1'b1;
      PS_ROM:   driveNow = romMode;
      PS_ROMEX: driveNow = romMode && (coreAddr >= EXT_LO);
      default:  driveNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ     <= 1'b0;
      cs2HitQ <= 1'b0;
      cs3HitQ <= 1'b0;
      intHitQ <= 1'b0;
      driveQ  <= 1'b0;
      busAddr <= '0;
      busDout <= '0;
    end else if (ctl.capture) begin
      wrQ     <= coreWr;
      cs2HitQ <= inRange(coreAddr, CS2_LO, CS2_HI);
      cs3HitQ <= inRange(coreAddr, CS3_LO, CS3_HI);
      intHitQ <= intNow;
      driveQ  <= driveNow;
      if (driveNow) begin
        busAddr <= coreAddr;
        if (coreWr) busDout <= coreWdata;
      end
    end
  end

  logic strobeOk;
  assign strobeOk = ctl.active && !(blkEn && intHitQ);

  always_comb begin
    cs2N = !(ctl.active && cs2HitQ);
    cs3N = !(ctl.active && cs3HitQ);
    rdN  = !(strobeOk && !wrQ);
    wrN  = !(strobeOk && wrQ);
  end

  always_comb begin
    unique case (pinMode)
      PIN_CS:   cs3PinN = cs3N;
      PIN_CSRD: cs3PinN = cs3N | rdN;
      PIN_CSWR: cs3PinN = cs3N | wrN;
      default:  cs3PinN = ~((cs3N | rdN) & (cs3N | wrN));
    endcase
  end

  always_comb begin
    unique case (psMode)
      PS_ON:   busOe = 1'b1;
      PS_OFF:  busOe = 1'b0;
      default: busOe = ctl.active && driveQ;
    endcase
  end

  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (cfgRdata[CFG_USED_W-1:0] == $past(cfgWdata[CFG_USED_W-1:0])));
  p_cs_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (cs2N && cs3N && rdN && wrN));
  p_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (blkEn && intHitQ) |-> (rdN && wrN));
  p_save_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (psMode == PS_OFF) |-> !busOe);
  p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(busDout) && $stable(busAddr)));
endmodule

// File: rtl/xbus_cs_ctrl.sv
module xbus_cs_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8,
  parameter logic [ADDR_W-1:0] CS2_LO = 16'h8000,
  parameter logic [ADDR_W-1:0] CS2_HI = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreRd,
  input  logic              coreWr,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic              romMode,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output logic              cs2N,
  output logic              cs3N,
  output logic              cs3PinN,
  output logic              rdN,
  output logic              wrN,
  output logic              busOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              coreReady
);
  busCtl_t ctl;
  logic    longAcc;

  xbus_ctl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_ctl (
    .clk(clk), .rstN(rstN), .req(coreRd | coreWr), .longAcc(longAcc), .ctl(ctl)
  );

  xbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS2_LO(CS2_LO), .CS2_HI(CS2_HI)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .coreAddr(coreAddr), .coreWr(coreWr),
    .coreWdata(coreWdata), .romMode(romMode), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .longAcc(longAcc), .cs2N(cs2N), .cs3N(cs3N),
    .cs3PinN(cs3PinN), .rdN(rdN), .wrN(wrN), .busOe(busOe), .busAddr(busAddr),
    .busDout(busDout)
  );

  assign coreReady = ctl.done;

  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreReady |-> (rdN && wrN && cs2N && cs3N));
  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  p_cs_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!cs2N, !cs3N}) <= 1);
endmodule

// File: tb/xbus_cs_ctrl_tb.sv
module xbus_cs_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] coreAddr = '0;
  logic        coreRd = 1'b0, coreWr = 1'b0;
  logic [7:0]  coreWdata = '0;
  logic        romMode = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        cs2N, cs3N, cs3PinN, rdN, wrN, busOe, coreReady;
  logic [15:0] busAddr;
  logic [7:0]  busDout;

  int checks = 0, failures = 0;
  int nCyc, nRd, nWr, nCs2, nCs3, nPin, nOe;
  bit quietDone;

  always #10 clk = ~clk;

  xbus_cs_ctrl u_dut (
    .clk(clk), .rstN(rstN), .coreAddr(coreAddr), .coreRd(coreRd), .coreWr(coreWr),
    .coreWdata(coreWdata), .romMode(romMode), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .cs2N(cs2N), .cs3N(cs3N), .cs3PinN(cs3PinN), .rdN(rdN),
    .wrN(wrN), .busOe(busOe), .busAddr(busAddr), .busDout(busDout), .coreReady(coreReady)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic doAccess(input logic [15:0] a, input bit wr, input logic [7:0] d);
    @(negedge clk);
    coreAddr = a; coreWr = wr; coreRd = !wr; coreWdata = d;
    @(posedge clk);
    nCyc = 0; nRd = 0; nWr = 0; nCs2 = 0; nCs3 = 0; nPin = 0; nOe = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (coreReady) break;
      nCyc++;
      if (!rdN) nRd++;
      if (!wrN) nWr++;
      if (!cs2N) nCs2++;
      if (!cs3N) nCs3++;
      if (!cs3PinN) nPin++;
      if (busOe) nOe++;
    end
    quietDone = coreReady && rdN && wrN && cs2N && cs3N;
    coreRd = 1'b0; coreWr = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "cfg after reset", cfgRdata, 8'h00);
    check("R2", "idle selects", {cs2N, cs3N, rdN, wrN}, 4'hF);
    check("R6", "idle ready", coreReady, 0);
    check("R8", "mode00 idle oe", busOe, 1);
    writeCfg(8'hFF);
    check("R1", "reserved bits", cfgRdata, 8'h3F);
    writeCfg(8'h00);
    check("R1", "cleared", cfgRdata, 8'h00);
  endtask

  task automatic testCs3Pin();
    doAccess(16'h2000, 1'b0, 8'h00);
    check("R4", "read length", nCyc, 4);
    check("R4", "rd low cycles", nRd, 4);
    check("R2", "cs3 low at 0x2000", nCs3, 4);
    check("R3", "mode00 pin low", nPin, 4);
    check("R6", "ready cycle quiet", quietDone, 1);
    doAccess(16'h5FFF, 1'b1, 8'h11);
    check("R4", "wr low cycles", nWr, 4);
    check("R2", "cs3 low at 0x5FFF", nCs3, 4);
    doAccess(16'h6000, 1'b0, 8'h00);
    check("R2", "cs3 high at 0x6000", nCs3, 0);
    writeCfg(8'h04);
    doAccess(16'h3000, 1'b0, 8'h00);
    check("R3", "mode01 read pin", nPin, 4);
    doAccess(16'h3000, 1'b1, 8'h22);
    check("R3", "mode01 write pin", nPin, 0);
    writeCfg(8'h08);
    doAccess(16'h3000, 1'b0, 8'h00);
    check("R3", "mode10 read pin", nPin, 0);
    doAccess(16'h3000, 1'b1, 8'h33);
    check("R3", "mode10 write pin", nPin, 4);
    writeCfg(8'h0C);
    check("R3", "mode11 idle pin", cs3PinN, 0);
    doAccess(16'h3000, 1'b0, 8'h00);
    check("R3", "mode11 read pin", nPin, 0);
    writeCfg(8'h00);
  endtask

  task automatic testWait();
    doAccess(16'h8000, 1'b0, 8'h00);
    check("R5", "cs2 no wait length", nCyc, 4);
    check("R2", "cs2 low", nCs2, 4);
    writeCfg(8'h10);
    doAccess(16'hFFFF, 1'b0, 8'h00);
    check("R5", "cs2 wait length", nCyc, 8);
    check("R5", "cs2 wait rd low", nRd, 8);
    doAccess(16'h4000, 1'b0, 8'h00);
    check("R5", "cs3 with wait enable", nCyc, 4);
    writeCfg(8'h00);
  endtask

  task automatic testBlock();
    doAccess(16'h1000, 1'b0, 8'h00);
    check("R7", "unblocked rd", nRd, 4);
    writeCfg(8'h20);
    doAccess(16'h1000, 1'b0, 8'h00);
    check("R7", "blocked rd", nRd, 0);
    check("R7", "blocked length", nCyc, 4);
    doAccess(16'h7FFF, 1'b1, 8'h44);
    check("R7", "blocked wr", nWr, 0);
    doAccess(16'h9000, 1'b1, 8'h45);
    check("R7", "external wr unblocked", nWr, 4);
    writeCfg(8'h00);
  endtask

  task automatic testPower();
    logic [7:0] keep;
    doAccess(16'h8100, 1'b1, 8'h5A);
    check("R10", "driven write data", busDout, 8'h5A);
    check("R8", "mode00 oe cycles", nOe, 4);
    writeCfg(8'h03);
    check("R8", "mode11 idle oe", busOe, 0);
    doAccess(16'h8200, 1'b1, 8'hA5);
    check("R8", "mode11 oe cycles", nOe, 0);
    check("R10", "gated data held", busDout, 8'h5A);
    check("R10", "gated addr held", busAddr, 16'h8100);
    writeCfg(8'h01);
    check("R9", "mode01 idle oe", busOe, 0);
    romMode = 1'b0;
    doAccess(16'h8300, 1'b1, 8'h77);
    check("R9", "mode01 rom off", nOe, 0);
    check("R10", "mode01 rom off data", busDout, 8'h5A);
    romMode = 1'b1;
    doAccess(16'h3000, 1'b0, 8'h00);
    check("R9", "mode01 rom on", nOe, 4);
    writeCfg(8'h02);
    doAccess(16'h3000, 1'b1, 8'h66);
    check("R9", "mode10 internal", nOe, 0);
    keep = busDout;
    check("R10", "mode10 internal held", keep, 8'h5A);
    writeCfg(8'h12);
    doAccess(16'h9000, 1'b1, 8'hC3);
    check("R9", "mode10 stretched oe", nOe, 8);
    check("R5", "mode10 stretched wr", nWr, 8);
    check("R10", "mode10 data", busDout, 8'hC3);
    romMode = 1'b0;
    doAccess(16'h9000, 1'b1, 8'h3C);
    check("R9", "mode10 rom off", nOe, 0);
    check("R5", "rom off length", nCyc, 8);
    writeCfg(8'h00);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCs3Pin();
    testWait();
    testBlock();
    testPower();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule